// File: doc/BRIEF.md
# Bit-Addressable GPIO Port Register File

This block is the register side of a general-purpose I/O port of up to 32 pins. It sits on a simple 32-bit register bus made of a byte address, a write strobe, write data and a combinational read-data return. It holds three registers. The drive-value register supplies the level of each pin. The drive-enable register decides which pins the port drives. The third register holds the pad levels after a two-flop synchronizer, and software can only read it.

Software needs no read-modify-write sequence to change single pins. Each of the two writable registers has a pair of write-only aliases. Writing a 1 to a bit of an alias sets or clears that bit. Writing a 0 leaves the bit as it was. Two agents can therefore update different pins of the same port without losing each other's changes. Bit i always belongs to pin i. The pad side sees the drive-value register as a value vector and the drive-enable register as an output-enable vector. Interrupt logic, pad multiplexing and clock gating are left to neighbouring blocks.

The register file has no sequencing states. Every bus write takes effect at the clock edge that samples it, and every read returns the addressed register in the same cycle.

Top module: `gpio_port_regs`

## Requirements
- R1: When reset ends, the drive-value and drive-enable registers are all zero. This makes every pin an input, with pad_oe and pad_out both zero.
- R2: A write to offset 0x00 loads the full drive-value register from the write data at that clock edge. From the next cycle pad_out and reads of 0x00 return the new value.
- R3: A write to offset 0x08 loads the full drive-enable register from the write data. pad_oe always equals that register, and reads of 0x08 return it. A 1 bit means the pin drives and a 0 bit means the pin is an input.
- R4: A write to offset 0x40 sets each drive-value bit whose write-data bit is 1 and leaves the other bits unchanged.
- R5: A write to offset 0x44 clears each drive-value bit whose write-data bit is 1 and leaves the other bits unchanged.
- R6: A write to offset 0x48 sets, and a write to offset 0x4C clears, each drive-enable bit whose write-data bit is 1. Bits written with 0 are left unchanged.
- R7: Reads of offset 0x04 return pad_in as it was two clock edges earlier. A change on pad_in is not visible after only one edge. Writes to 0x04 change no register.
- R8: A write to any offset other than 0x00, 0x08, 0x40, 0x44, 0x48 or 0x4C changes no register. Reads of any offset other than 0x00, 0x04 or 0x08 return zero. This covers the four alias offsets and unaligned offsets.
- R9: Bit i of every register, alias and vector belongs to pin i. pad_out carries the drive-value register for every pin, including pins that are inputs, so a pin that becomes an output drives the value stored earlier.
- R10: While bus_we is 0, no register changes, whatever the address and write data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Combinational read data for bus_addr |
| pad_in | input | NPINS (32) | Levels seen at the pads, asynchronous to clk |
| pad_out | output | NPINS (32) | Drive value for each pin |
| pad_oe | output | NPINS (32) | Output enable for each pin, 1 = drive |

## Verification
The assertions check on every cycle the update rule for each write offset: a full load, OR-in for the set aliases and AND-out for the clear aliases. They also check that ignored writes and idle cycles leave both registers unchanged, that reads of the writable registers match the pad vectors, that unmapped reads return zero, and the two-edge latency of the input path. Other behaviours can only be shown by the bench's scenarios. These are the reset values and the walk of a single bit across every pin position. They also include a stored drive value that persists while its pin is an input and then appears once the pin is turned around, and the point that a pad change is still hidden after one edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    // Byte offsets that the decoder recognises.
    localparam logic [7:0] OFS_DRV     = 8'h00;
    localparam logic [7:0] OFS_PIN     = 8'h04;
    localparam logic [7:0] OFS_OE      = 8'h08;
    localparam logic [7:0] OFS_DRV_SET = 8'h40;
    localparam logic [7:0] OFS_DRV_CLR = 8'h44;
    localparam logic [7:0] OFS_OE_SET  = 8'h48;
    localparam logic [7:0] OFS_OE_CLR  = 8'h4C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DRV,
        SEL_PIN,
        SEL_OE,
        SEL_DRV_SET,
        SEL_DRV_CLR,
        SEL_OE_SET,
        SEL_OE_CLR
    } reg_sel_e;

    typedef enum logic [1:0] {
        OP_HOLD,
        OP_LOAD,
        OP_SET,
        OP_CLR
    } reg_op_e;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    always_comb begin
        sel = SEL_NONE;
        unique case (addr)
            ADDR_W'(OFS_DRV):     sel = SEL_DRV;
            ADDR_W'(OFS_PIN):     sel = SEL_PIN;
            ADDR_W'(OFS_OE):      sel = SEL_OE;
            ADDR_W'(OFS_DRV_SET): sel = SEL_DRV_SET;
            ADDR_W'(OFS_DRV_CLR): sel = SEL_DRV_CLR;
            ADDR_W'(OFS_OE_SET):  sel = SEL_OE_SET;
            ADDR_W'(OFS_OE_CLR):  sel = SEL_OE_CLR;
            default:              sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/gpio_bit_reg.sv
module gpio_bit_reg
    import gpio_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  reg_op_e      op,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    logic [W-1:0] q_next;

    always_comb begin
        q_next = q;
        unique case (op)
            OP_HOLD: q_next = q;
            OP_LOAD: q_next = wdata;
            OP_SET:  q_next = q | wdata;
            OP_CLR:  q_next = q & ~wdata;
            default: q_next = q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= q_next;
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe
);

    reg_sel_e         sel;
    reg_op_e          drv_op;
    reg_op_e          oe_op;
    logic [NPINS-1:0] drv_q;
    logic [NPINS-1:0] oe_q;
    logic [NPINS-1:0] pin_q;
    logic [NPINS-1:0] wbits;

    assign wbits = bus_wdata[NPINS-1:0];

    gpio_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    always_comb begin
        drv_op = OP_HOLD;
        oe_op  = OP_HOLD;
        if (bus_we) begin
            unique case (sel)
                SEL_DRV:     drv_op = OP_LOAD;
                SEL_DRV_SET: drv_op = OP_SET;
                SEL_DRV_CLR: drv_op = OP_CLR;
                SEL_OE:      oe_op  = OP_LOAD;
                SEL_OE_SET:  oe_op  = OP_SET;
                SEL_OE_CLR:  oe_op  = OP_CLR;
                default:     ;
            endcase
        end
    end

    gpio_bit_reg #(.W(NPINS)) u_drv (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (drv_op),
        .wdata (wbits),
        .q     (drv_q)
    );

    gpio_bit_reg #(.W(NPINS)) u_oe (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (oe_op),
        .wdata (wbits),
        .q     (oe_q)
    );

    gpio_in_sync #(.W(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pin_q)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_DRV: bus_rdata[NPINS-1:0] = drv_q;
            SEL_PIN: bus_rdata[NPINS-1:0] = pin_q;
            SEL_OE:  bus_rdata[NPINS-1:0] = oe_q;
            default: ;
        endcase
    end

    assign pad_out = drv_q;
    assign pad_oe  = oe_q;

endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk
    import gpio_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NPINS-1:0]  pad_in,
    input logic [NPINS-1:0]  pad_out,
    input logic [NPINS-1:0]  pad_oe
);

    logic [1:0] live_cnt;
    logic       wr_mapped;
    logic       rd_mapped;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_cnt <= '0;
        end else if (live_cnt != 2'd3) begin
            live_cnt <= live_cnt + 2'd1;
        end
    end

    assign wr_mapped = (bus_addr == ADDR_W'(OFS_DRV))     || (bus_addr == ADDR_W'(OFS_OE))     ||
                       (bus_addr == ADDR_W'(OFS_DRV_SET)) || (bus_addr == ADDR_W'(OFS_DRV_CLR)) ||
                       (bus_addr == ADDR_W'(OFS_OE_SET))  || (bus_addr == ADDR_W'(OFS_OE_CLR));
    assign rd_mapped = (bus_addr == ADDR_W'(OFS_DRV)) || (bus_addr == ADDR_W'(OFS_PIN)) ||
                       (bus_addr == ADDR_W'(OFS_OE));

    assert_drv_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFS_DRV)) |=> pad_out == $past(bus_wdata[NPINS-1:0]));

    assert_drv_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFS_DRV)) |-> bus_rdata[NPINS-1:0] == pad_out);

    assert_oe_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFS_OE)) |=> pad_oe == $past(bus_wdata[NPINS-1:0]));

    assert_oe_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFS_OE)) |-> bus_rdata[NPINS-1:0] == pad_oe);

    assert_drv_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFS_DRV_SET)) |=>
        pad_out == ($past(pad_out) | $past(bus_wdata[NPINS-1:0])) && $stable(pad_oe));

    assert_drv_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFS_DRV_CLR)) |=>
        pad_out == ($past(pad_out) & ~$past(bus_wdata[NPINS-1:0])) && $stable(pad_oe));

    assert_oe_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFS_OE_SET)) |=>
        pad_oe == ($past(pad_oe) | $past(bus_wdata[NPINS-1:0])) && $stable(pad_out));

    assert_oe_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFS_OE_CLR)) |=>
        pad_oe == ($past(pad_oe) & ~$past(bus_wdata[NPINS-1:0])) && $stable(pad_out));

    assert_pin_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt >= 2'd2 && bus_addr == ADDR_W'(OFS_PIN)) |->
        bus_rdata[NPINS-1:0] == $past(pad_in, 2));

    assert_unmapped_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !wr_mapped) |=> $stable(pad_out) && $stable(pad_oe));

    assert_unmapped_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_mapped |-> bus_rdata == '0);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(pad_out) && $stable(pad_oe));

endmodule

bind gpio_port_regs gpio_port_regs_chk #(
    .NPINS  (NPINS),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (.*);

// File: tb/gpio_port_regs_tb.sv
module gpio_port_regs_tb;

    localparam int NPINS  = 32;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [NPINS-1:0]  pad_in = '0;
    logic [NPINS-1:0]  pad_out;
    logic [NPINS-1:0]  pad_oe;

    int n_checks = 0;
    int n_fails  = 0;
    logic [31:0] exp_drv = '0;
    logic [31:0] exp_oe  = '0;

    always #2 clk = ~clk;

    gpio_port_regs #(.NPINS(NPINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // Drive at the falling edge, let one rising edge sample it, return at the next falling edge.
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
        bus_wdata = 32'hDEAD_BEEF;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic check_regs(input string tag);
        logic [31:0] r;
        bus_read(8'h00, r);
        check({tag, " read drv"}, r, exp_drv);
        bus_read(8'h08, r);
        check({tag, " read oe"}, r, exp_oe);
        check({tag, " pad_out"}, pad_out, exp_drv);
        check({tag, " pad_oe"}, pad_oe, exp_oe);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check_regs("R1 reset");
    endtask

    task automatic t_plain_load;
        bus_write(8'h00, 32'hA5A5_0F0F); exp_drv = 32'hA5A5_0F0F;
        check_regs("R2 load drv");
        bus_write(8'h08, 32'h00FF_00FF); exp_oe = 32'h00FF_00FF;
        check_regs("R3 load oe");
        bus_write(8'h00, 32'h1234_5678); exp_drv = 32'h1234_5678;
        check_regs("R2 reload drv");
    endtask

    task automatic t_drv_alias;
        bus_write(8'h40, 32'h8000_0001); exp_drv = exp_drv | 32'h8000_0001;
        check_regs("R4 drv set");
        bus_write(8'h40, 32'h0000_0000);
        check_regs("R4 drv set zero");
        bus_write(8'h44, 32'h1200_0070); exp_drv = exp_drv & ~32'h1200_0070;
        check_regs("R5 drv clr");
        bus_write(8'h44, 32'hFFFF_FFFF); exp_drv = '0;
        check_regs("R5 drv clr all");
    endtask

    task automatic t_oe_alias;
        bus_write(8'h48, 32'hF000_0000); exp_oe = exp_oe | 32'hF000_0000;
        check_regs("R6 oe set");
        bus_write(8'h4C, 32'h00F0_0003); exp_oe = exp_oe & ~32'h00F0_0003;
        check_regs("R6 oe clr");
    endtask

    task automatic t_walk_bits;
        bus_write(8'h00, 32'h0); exp_drv = '0;
        bus_write(8'h08, 32'h0); exp_oe = '0;
        for (int i = 0; i < NPINS; i++) begin
            bus_write(8'h40, 32'h1 << i);
            check("R9 walk set", pad_out, 32'h1 << i);
            bus_write(8'h44, 32'h1 << i);
        end
        // Stored value while input, driven once turned to output.
        bus_write(8'h40, 32'h0000_0100); exp_drv = 32'h0000_0100;
        check("R9 value held while input", pad_out, 32'h0000_0100);
        check("R9 still input", pad_oe, 32'h0);
        bus_write(8'h48, 32'h0000_0100); exp_oe = 32'h0000_0100;
        check_regs("R9 turnaround");
    endtask

    task automatic t_input_sync;
        logic [31:0] r;
        @(negedge clk);
        pad_in = 32'hCAFE_F00D;
        @(negedge clk);
        bus_read(8'h04, r);
        check("R7 one edge hidden", r, 32'h0);
        @(negedge clk);
        bus_read(8'h04, r);
        check("R7 two edges visible", r, 32'hCAFE_F00D);
        pad_in = 32'h0F0F_0001;
        @(negedge clk);
        @(negedge clk);
        bus_read(8'h04, r);
        check("R7 second pattern", r, 32'h0F0F_0001);
        bus_write(8'h04, 32'hFFFF_FFFF);
        check_regs("R7 write to input ignored");
        bus_read(8'h04, r);
        check("R7 input after write", r, 32'h0F0F_0001);
    endtask

    task automatic t_unmapped;
        logic [31:0] r;
        bus_write(8'h0C, 32'hFFFF_FFFF);
        check_regs("R8 write 0x0C");
        bus_write(8'h01, 32'hFFFF_FFFF);
        check_regs("R8 write unaligned");
        bus_write(8'h80, 32'hFFFF_FFFF);
        check_regs("R8 write 0x80");
        bus_read(8'h40, r); check("R8 read 0x40", r, 32'h0);
        bus_read(8'h44, r); check("R8 read 0x44", r, 32'h0);
        bus_read(8'h48, r); check("R8 read 0x48", r, 32'h0);
        bus_read(8'h4C, r); check("R8 read 0x4C", r, 32'h0);
        bus_read(8'h10, r); check("R8 read 0x10", r, 32'h0);
        bus_read(8'h09, r); check("R8 read unaligned", r, 32'h0);
    endtask

    task automatic t_no_we;
        @(negedge clk);
        bus_we    = 1'b0;
        bus_addr  = 8'h00;
        bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        bus_addr  = 8'h40;
        @(negedge clk);
        bus_addr  = 8'h4C;
        @(negedge clk);
        check_regs("R10 no strobe");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_plain_load;
        t_drv_alias;
        t_oe_alias;
        t_walk_bits;
        t_input_sync;
        t_unmapped;
        t_no_we;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #400000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule